// File: doc/BRIEF.md
# Bus Master Burst Time Limiter

This block bounds how long a DMA master may keep ownership of a shared bus during one burst. Software writes a 24-bit cycle budget into a configuration register. When the master signals the start of a burst, a down-counter takes the budget and then counts one step for each bus clock while the burst is active. When the counter runs out, the block does not cut the bus off at once. It waits for the data phase that is in flight to complete, and only then raises a release request that tells the master to give up the bus.

A budget of zero turns the limit off, so bursts run for as long as the master wants. The release request is a level. The master lowers its burst-active signal in reply, and that clears the request. A status output shows that the budget of the current burst has run out. The bus protocol and arbitration belong to the surrounding logic.

Top module: `burst_time_limiter`

## Requirements
- R1: After reset the budget register reads 0, and release_req and expired are both low.
- R2: When cfg_wr_en is high at a clock edge, all 24 bits of cfg_wr_data are stored, and cfg_rd_data shows them from the next cycle on.
- R3: A budget of 0 disables the limit. A burst started with a zero budget never raises expired or release_req, however long it runs.
- R4: At an edge where burst_start is high, the counter loads the budget value L. expired goes high after exactly L further edges at which burst_active is high and burst_start is low.
- R5: release_req rises only in the cycle after an edge where xfer_done is high while expired is already high. A transfer that completes before expiry does not release the bus.
- R6: Once release_req is high it stays high while burst_active remains high, and it goes low in the cycle after an edge where burst_active is low.
- R7: After expiry the counter holds at zero, and expired stays high until the burst ends or a new burst starts.
- R8: If burst_active goes low before expiry, the counter is cleared and the limiter disarmed. No release is raised, even if burst_active is later raised again without a new burst_start.
- R9: A write during a burst changes only later bursts. If the write and burst_start fall on the same edge, the counter loads the value held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the budget register |
| cfg_wr_data | input | 24 | Budget value to write |
| cfg_rd_data | output | 24 | Current budget register value |
| burst_start | input | 1 | One-cycle pulse at the start of a DMA burst |
| burst_active | input | 1 | High while the master holds the bus |
| xfer_done | input | 1 | Strobe marking completion of the current data phase |
| release_req | output | 1 | Level request to end the burst and free the bus |
| expired | output | 1 | The budget of the current burst has run out |

## Verification
The assertions check on every cycle that release_req rises only after a transfer completes while the budget is exhausted, that it holds until burst_active falls and then drops, that expiry persists once reached, that loading a zero or non-zero budget never shows expiry at once, and that register writes land. Only the bench scenarios can show the exact cycle of expiry for a given budget, that a write made mid-burst leaves the running count untouched, and that a burst ended early leaves the limiter disarmed when burst_active is raised again without a start.

// File: rtl/burst_time_limiter.sv
module burst_time_limiter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_en,
  input  logic [CNT_W-1:0] cfg_wr_data,
  output logic [CNT_W-1:0] cfg_rd_data,
  input  logic             burst_start,
  input  logic             burst_active,
  input  logic             xfer_done,
  output logic             release_req,
  output logic             expired
);

  logic [CNT_W-1:0] budget_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic             rel_q;

  assign cfg_rd_data = budget_q;
  assign expired     = armed_q && (cnt_q == '0);
  assign release_req = rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      rel_q    <= 1'b0;
    end else begin
      if (cfg_wr_en) budget_q <= cfg_wr_data;
      if (burst_start) begin
        cnt_q   <= budget_q;
        armed_q <= |budget_q;
        rel_q   <= 1'b0;
      end else if (!burst_active) begin
        cnt_q   <= '0;
        armed_q <= 1'b0;
        rel_q   <= 1'b0;
      end else begin
        if (armed_q && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
        if (expired && xfer_done) rel_q <= 1'b1;
      end
    end
  end

endmodule

module burst_time_limiter_chk #(
  parameter int CNT_W = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_wr_en,
  input logic [CNT_W-1:0] cfg_wr_data,
  input logic [CNT_W-1:0] cfg_rd_data,
  input logic             burst_start,
  input logic             burst_active,
  input logic             xfer_done,
  input logic             release_req,
  input logic             expired
);

  p_wr_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_en |=> cfg_rd_data == $past(cfg_wr_data));

  p_zero_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start && cfg_rd_data == '0 |=> !expired);

  p_load_fresh_r4: assert property (@(posedge clk) disable iff (!rst_n)
    burst_start |=> !expired);

  p_rel_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !release_req ##1 release_req |-> $past(expired && xfer_done && burst_active));

  p_rel_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    release_req && burst_active && !burst_start |=> release_req);

  p_rel_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active && !burst_start |=> !release_req);

  p_exp_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    expired && burst_active && !burst_start |=> expired);

  p_end_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !burst_active && !burst_start |=> !expired);

endmodule

bind burst_time_limiter burst_time_limiter_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/burst_time_limiter_tb.sv
module burst_time_limiter_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [23:0] cfg_wr_data = '0;
  logic [23:0] cfg_rd_data;
  logic        burst_start = 1'b0;
  logic        burst_active = 1'b0;
  logic        xfer_done = 1'b0;
  logic        release_req;
  logic        expired;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  burst_time_limiter dut_i (.*);

  localparam int NV = 9;
  localparam logic [23:0] V_LIM [NV] = '{24'd0, 24'd3, 24'd3, 24'd1, 24'd1, 24'd5, 24'd8, 24'd2, 24'd6};
  localparam int          V_K   [NV] = '{5, 3, 4, 2, 1, 10, 2, 3, 7};
  localparam bit          V_REL [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};

  task automatic chk(input string req, input logic [23:0] got, input logic [23:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [23:0] v);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wr_data = v;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  task automatic start_burst();
    @(negedge clk);
    burst_start = 1'b1; burst_active = 1'b1;
    @(negedge clk);
    burst_start = 1'b0;
  endtask

  task automatic end_burst(input string req);
    burst_active = 1'b0;
    @(negedge clk);
    chk(req, {23'd0, release_req}, 24'd0);
    chk(req, {23'd0, expired}, 24'd0);
  endtask

  // xfer_done sampled at edge k after the start edge
  task automatic xfer_at(input int k);
    repeat (k - 1) @(negedge clk);
    xfer_done = 1'b1;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #20;
    @(negedge clk);
    chk("R1 reg", cfg_rd_data, 24'd0);
    chk("R1 rel", {23'd0, release_req}, 24'd0);
    chk("R1 exp", {23'd0, expired}, 24'd0);
    rst_n = 1'b1;

    wr(24'hFFFFFF);
    chk("R2 all ones", cfg_rd_data, 24'hFFFFFF);
    wr(24'hA5C3E1);
    chk("R2 pattern", cfg_rd_data, 24'hA5C3E1);

    // table: R3 zero budget, R4 expiry timing, R5 release after completing access
    for (int i = 0; i < NV; i++) begin
      wr(V_LIM[i]);
      start_burst();
      xfer_at(V_K[i]);
      chk("R4/R3 expired", {23'd0, expired},
          {23'd0, (V_LIM[i] != 0) && (V_K[i] >= int'(V_LIM[i]))});
      chk("R5/R3 release", {23'd0, release_req}, {23'd0, V_REL[i]});
      end_burst("R6 drop");
    end

    // R3 long zero-budget burst
    wr(24'd0);
    start_burst();
    for (int c = 0; c < 40; c++) begin
      xfer_done = 1'b1;
      @(negedge clk);
    end
    xfer_done = 1'b0;
    chk("R3 long", {22'd0, release_req, expired}, 24'd0);
    end_burst("R3 end");

    // R4 exact expiry edge, R7 hold at zero, R6 level hold
    wr(24'd4);
    start_burst();
    repeat (3) @(negedge clk);
    chk("R4 before", {23'd0, expired}, 24'd0);
    @(negedge clk);
    chk("R4 at", {23'd0, expired}, 24'd1);
    repeat (20) @(negedge clk);
    chk("R7 hold", {23'd0, expired}, 24'd1);
    chk("R5 no xfer", {23'd0, release_req}, 24'd0);
    xfer_at(1);
    chk("R5 rise", {23'd0, release_req}, 24'd1);
    repeat (10) @(negedge clk);
    chk("R6 hold", {23'd0, release_req}, 24'd1);
    end_burst("R6 clear");

    // R8 early end, re-raise active without start
    wr(24'd5);
    start_burst();
    @(negedge clk);
    burst_active = 1'b0;
    @(negedge clk);
    chk("R8 cleared", {23'd0, expired}, 24'd0);
    burst_active = 1'b1;
    for (int c = 0; c < 12; c++) begin
      xfer_done = 1'b1;
      @(negedge clk);
    end
    xfer_done = 1'b0;
    chk("R8 disarmed", {22'd0, release_req, expired}, 24'd0);
    end_burst("R8 end");

    // R9 write mid-burst
    wr(24'd4);
    start_burst();
    cfg_wr_en = 1'b1; cfg_wr_data = 24'd1;
    @(negedge clk);
    cfg_wr_en = 1'b0;
    xfer_at(2);
    chk("R9 old value kept", {22'd0, release_req, expired}, 24'd0);
    end_burst("R9 end");
    start_burst();
    xfer_at(2);
    chk("R9 new value used", {23'd0, release_req}, 24'd1);
    end_burst("R9 end2");

    // R9 write and start on same edge
    wr(24'd2);
    @(negedge clk);
    burst_start = 1'b1; burst_active = 1'b1;
    cfg_wr_en = 1'b1; cfg_wr_data = 24'd9;
    @(negedge clk);
    burst_start = 1'b0; cfg_wr_en = 1'b0;
    @(negedge clk);
    chk("R9 same edge pre", {23'd0, expired}, 24'd0);
    @(negedge clk);
    chk("R9 same edge old", {23'd0, expired}, 24'd1);
    end_burst("R9 end3");
    chk("R9 reg updated", cfg_rd_data, 24'd9);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule